// File: doc/BRIEF.md
# Three-Wire Register Access Master

This block is a synchronous master for a serial register bus made of three lines: a framing line, a bit clock and a bidirectional data line. A host hands it one register transaction at a time. Each transaction is a read or a write of a 24-bit register selected by an 8-bit address. The master serialises the address and then either sends the write data or clocks in the read data. When the frame is complete it returns the read value with a one-cycle done pulse.

The framing line marks where a frame starts and ends, and it also changes level in the middle of the address. During the first half of the address it is low. It rises for the second half and stays high through the data field. Every bit takes two line phases: a clock-low phase, in which the new bit is placed on the data line, and a clock-high phase, in which that bit is held. A parameter sets the length of each line phase in system clocks.

The request side is a valid/ready port. A request is taken on the cycle in which both `req_valid` and `req_ready` are high. `req_ready` is high only while the master is idle. A host that holds `req_valid` high while the master is busy is simply kept waiting, and the request it presents is not used. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and `rsp_rdata` must be taken in that cycle.

Top module: `tw_reg_master`

## Requirements
- R1: Out of reset and whenever idle, `bus_period_o`, `bus_clock_o` and `bus_data_o` are all 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is 0 from acceptance until the cycle after the done pulse. Requests presented while busy start no frame.
- R3: A frame opens with exactly one line phase in which `bus_period_o` is 0 while `bus_clock_o` and `bus_data_o` are 1.
- R4: Each bit is one phase with `bus_clock_o` at 0 and `bus_data_o` equal to the bit, followed by one phase with `bus_clock_o` at 1 and `bus_data_o` unchanged. Every clock-low and clock-high phase lasts `PHASE_CLKS` system clocks.
- R5: A frame carries 32 bits: the 8 address bits and then the 24 data bits, each field least significant bit first.
- R6: `bus_period_o` is 0 during address bits 0 to 3, and 1 during address bits 4 to 7 and all 24 data bits.
- R7: On a read (`req_write` = 0), `bus_data_o` is 1 (released) for all 24 data bits. `bus_data_i` passes through a two-flop synchronizer and is sampled in the last system clock of each clock-high phase. The first sampled bit becomes bit 0 of `rsp_rdata`. The responder must change the line when the clock falls, and `PHASE_CLKS` must be at least 2 for reads.
- R8: After the last bit, `bus_period_o` is 0 for one phase and then 1 for one phase, with `bus_clock_o` and `bus_data_o` both 1 throughout.
- R9: `rsp_valid` is high for exactly one cycle, in the cycle right after the final framing-high phase. `rsp_rdata` is 0 after a write. `req_ready` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Master idle and able to take a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 24 | Write data |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 24 | Read data, valid with `rsp_valid` |
| bus_period_o | output | 1 | Framing line |
| bus_clock_o | output | 1 | Bit clock line |
| bus_data_o | output | 1 | Data line drive; 1 releases the line |
| bus_data_i | input | 1 | Data line as seen on the wire |

## Verification
Two events can coincide: the done pulse of one transaction and a request for the next that is already waiting. The bench provokes this by keeping the next request valid across the end of the frame, with a read following a write and another read following that read. It then checks that the new request is accepted exactly one cycle after the done pulse, and never during it. A scoreboard decodes every frame from the three bus lines and matches it against the queued requests. In the same way, a burst of requests presented mid-frame must not add any frame.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_END_LO,
    ST_END_HI,
    ST_DONE
  } tw_state_e;
endpackage

// File: rtl/tw_sync2.sv
module tw_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
  parameter int PHASE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= LOAD;
    end else if (!run_i || cnt_q == '0) begin
      cnt_q <= LOAD;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/tw_sequencer.sv
module tw_sequencer
  import tw_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 24,
  parameter int ADDR_LO_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              din_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              run_o,
  output logic              period_o,
  output logic              clock_o,
  output logic              data_o
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] DATA_IDX0 = IDX_W'(ADDR_W);
  localparam logic [IDX_W-1:0] PHI_IDX0  = IDX_W'(ADDR_LO_BITS);

  tw_state_e           state_q;
  logic [IDX_W-1:0]    idx_q;
  logic                high_q;
  logic                wr_q;
  logic [FRAME_W-1:0]  tx_q;
  logic [DATA_W-1:0]   rx_q;
  logic                in_data;

  assign in_data = (idx_q >= DATA_IDX0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      high_q  <= 1'b0;
      wr_q    <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_START;
            wr_q    <= req_write;
            tx_q    <= {req_wdata, req_addr};
            rx_q    <= '0;
            idx_q   <= '0;
            high_q  <= 1'b0;
          end
        end
        ST_START: if (tick_i) state_q <= ST_BIT;
        ST_BIT: begin
          if (tick_i) begin
            if (!high_q) begin
              high_q <= 1'b1;
            end else begin
              high_q <= 1'b0;
              tx_q   <= tx_q >> 1;
              if (!wr_q && in_data) rx_q <= {din_i, rx_q[DATA_W-1:1]};
              if (idx_q == LAST_IDX) state_q <= ST_END_LO;
              else                   idx_q   <= idx_q + 1'b1;
            end
          end
        end
        ST_END_LO: if (tick_i) state_q <= ST_END_HI;
        ST_END_HI: if (tick_i) state_q <= ST_DONE;
        ST_DONE:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    period_o = 1'b1;
    clock_o  = 1'b1;
    data_o   = 1'b1;
    case (state_q)
      ST_START:  period_o = 1'b0;
      ST_END_LO: period_o = 1'b0;
      ST_BIT: begin
        period_o = (idx_q >= PHI_IDX0);
        clock_o  = high_q;
        data_o   = (!wr_q && in_data) ? 1'b1 : tx_q[0];
      end
      default: ;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_rdata = rx_q;
  assign run_o     = (state_q == ST_START) || (state_q == ST_BIT) ||
                     (state_q == ST_END_LO) || (state_q == ST_END_HI);
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 24,
  parameter int ADDR_LO_BITS = 4,
  parameter int PHASE_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_period_o,
  output logic              bus_clock_o,
  output logic              bus_data_o,
  input  logic              bus_data_i
);
  logic tick, run, din_sync;

  tw_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (bus_data_i),
    .q_o   (din_sync)
  );

  tw_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  tw_sequencer #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .ADDR_LO_BITS (ADDR_LO_BITS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .din_i     (din_sync),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .run_o     (run),
    .period_o  (bus_period_o),
    .clock_o   (bus_clock_o),
    .data_o    (bus_data_o)
  );
endmodule

// File: rtl/tw_reg_master_chk.sv
module tw_reg_master_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_period_o,
  input logic              bus_clock_o,
  input logic              bus_data_o,
  input logic              bus_data_i
);
  a_r1_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_period_o && bus_clock_o && bus_data_o));

  a_r2_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_frame_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!bus_period_o && bus_clock_o && bus_data_o));

  a_r4_clock_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clock_o |-> (!req_ready && !rsp_valid));

  a_r8_period_falls_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_period_o) |-> (bus_clock_o && bus_data_o));

  a_r9_done_single_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

bind tw_reg_master tw_reg_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tw_reg_master_tb.sv
module tw_reg_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 2;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_addr;
  logic [23:0] req_wdata;
  logic        rsp_valid;
  logic [23:0] rsp_rdata;
  logic        bus_period_o, bus_clock_o, bus_data_o, bus_data_i;
  logic        dev_bit;

  assign bus_data_i = bus_data_o & dev_bit;

  tw_reg_master #(.PHASE_CLKS(PHASE)) u_dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          wr;
    logic [7:0]  addr;
    logic [23:0] data;
  } item_t;

  item_t       frame_q[$];
  logic [23:0] rsp_q[$];
  int checks = 0, errors = 0;
  int cyc = 0, done_cyc = -10, rise_cyc = -10, frames = 0, sent = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor / responder model / scoreboard
  logic prev_p = 1'b1, prev_c = 1'b1, prev_d = 1'b1;
  bit in_fr = 0, end_lo = 0, per_ok, width_ok, rel_ok, hold_ok;
  int nbits, nfall, since, lo_start;
  logic [7:0]  got_addr;
  logic [23:0] got_data;
  item_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_fr) begin
        if (prev_p && !bus_period_o && bus_clock_o) begin
          in_fr = 1; end_lo = 0; nbits = 0; nfall = 0; since = 1;
          per_ok = 1; width_ok = 1; rel_ok = 1; hold_ok = 1;
          got_addr = '0; got_data = '0;
          check(bus_data_o == 1'b1, "R3", "data at frame open", 32'(bus_data_o), 1);
          if (frame_q.size() == 0) begin
            check(0, "R2", "frame without accepted request", 1, 0);
            cur = '{wr: 1'b1, addr: 8'h0, data: 24'h0};
          end else cur = frame_q.pop_front();
        end
      end else begin
        if (prev_c != bus_clock_o) begin
          if (since != PHASE) width_ok = 0;   // R4 phase length
          since = 1;
          if (!bus_clock_o) begin
            nfall++;
            if (!cur.wr && nfall > 8) dev_bit = cur.data[nfall-9];
            else dev_bit = 1'b1;
          end else begin
            if (bus_period_o != (nbits >= 4)) per_ok = 0;
            if (nbits < 8) got_addr[nbits] = bus_data_o;
            else if (cur.wr) got_data[nbits-8] = bus_data_o;
            else if (!bus_data_o) rel_ok = 0;
            nbits++;
          end
        end else begin
          since++;
          if (bus_clock_o && bus_data_o != prev_d && bus_period_o == prev_p && nbits > 0)
            hold_ok = 0;
        end
        if (nbits == 32 && !end_lo && prev_p && !bus_period_o) begin
          end_lo = 1; lo_start = cyc;
          check(bus_clock_o && bus_data_o, "R8", "clock/data at closing low",
                {30'd0, bus_clock_o, bus_data_o}, 3);
        end else if (end_lo && !prev_p && bus_period_o) begin
          check(cyc - lo_start == PHASE, "R8", "closing low length", cyc - lo_start, PHASE);
          check(got_addr == cur.addr, "R5", "address bits", 32'(got_addr), 32'(cur.addr));
          if (cur.wr)
            check(got_data == cur.data, "R5", "write data bits", 32'(got_data), 32'(cur.data));
          else
            check(rel_ok, "R7", "data released on read", 32'(rel_ok), 1);
          check(per_ok, "R6", "period level per bit", 32'(per_ok), 1);
          check(width_ok, "R4", "phase lengths", 32'(width_ok), 1);
          check(hold_ok, "R4", "data held in clock-high", 32'(hold_ok), 1);
          rise_cyc = cyc; in_fr = 0; dev_bit = 1'b1; frames++;
        end
      end
      if (rsp_valid) begin
        check(cyc == rise_cyc + PHASE, "R9", "done pulse timing", cyc, rise_cyc + PHASE);
        if (rsp_q.size() == 0) check(0, "R9", "unexpected done", 1, 0);
        else begin
          logic [23:0] e;
          e = rsp_q.pop_front();
          check(rsp_rdata == e, "R7", "response data (R9 zero on write)", 32'(rsp_rdata), 32'(e));
        end
        done_cyc = cyc;
      end
    end
    prev_p = bus_period_o; prev_c = bus_clock_o; prev_d = bus_data_o;
  end

  task automatic send(input bit wr, input logic [7:0] a, input logic [23:0] d, input bit b2b);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (b2b) check(cyc == done_cyc + 1, "R9", "back-to-back accept after done", cyc, done_cyc + 1);
    frame_q.push_back('{wr: wr, addr: a, data: d});
    rsp_q.push_back(wr ? 24'h0 : d);
    sent++;
    @(posedge clk);
  endtask

  task automatic release_req();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(rsp_q.size() == 0 && req_ready));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; dev_bit = 1'b1;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1", "ready/done after reset",
          {30'd0, req_ready, rsp_valid}, 2);
    check(bus_period_o && bus_clock_o && bus_data_o, "R1", "idle lines",
          {29'd0, bus_period_o, bus_clock_o, bus_data_o}, 7);

    send(1, 8'hA5, 24'h123456, 0); release_req(); wait_idle();
    check(bus_period_o && bus_clock_o && bus_data_o, "R1", "lines after write",
          {29'd0, bus_period_o, bus_clock_o, bus_data_o}, 7);
    send(0, 8'h5A, 24'hC3A51F, 0); release_req(); wait_idle();

    send(1, 8'h00, 24'hFFFFFF, 0);
    send(0, 8'hFF, 24'h000001, 1);
    send(0, 8'h81, 24'h800000, 1);
    release_req(); wait_idle();

    // R2: requests presented while busy must be ignored
    send(1, 8'h12, 24'h0F0F0F, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_addr = 8'h3C; req_wdata = 24'hDEAD01; req_write = 1'b0; req_valid = 1'b1;
      if (req_ready) check(0, "R2", "ready while busy", 1, 0);
    end
    release_req(); wait_idle();
    repeat (10) @(negedge clk);
    check(frames == sent, "R2", "frame count", frames, sent);
    check(frame_q.size() == 0, "R2", "pending frames", frame_q.size(), 0);
    finish_run();
  end
endmodule